// File: doc/BRIEF.md
# Windowed Downward System Stack Pointer

This block holds the system stack pointer for an on-chip RAM that is organised in 16-bit words. It turns push and pop strobes into RAM write and read cycles. The stack grows toward lower byte addresses, and the pointer always moves by one word, which is two bytes. The pointer addresses the word most recently pushed. A push writes at the pointer minus two and then moves the pointer there. A pop reads at the pointer and then moves the pointer up by two. The RAM is synchronous, so the popped word comes back one cycle later on the read-data port.

A 3-bit size code chooses a stack window. Most codes place the window top at 0xFBFE. One code places the top at 0xFDFE. Two codes are reserved. Software can write a lower limit register and an upper limit register. A push whose resulting pointer falls below the lower limit sets a sticky overflow flag. A pop whose resulting pointer rises above the upper limit sets a sticky underflow flag.

When circular mode is enabled and the code allows it, the pointer wraps inside the window. Only the low address bits that the window covers are replaced. The bits above them are kept from the current pointer.

A small controller has two states:
- `ST_IDLE`: no popped data is pending.
- `ST_RDATA`: popped data is valid on `pop_data_o` during this cycle.

Its transitions are:
- `IDLE->RDATA`: a pop is accepted.
- `RDATA->RDATA`: a pop is accepted again (back-to-back pops).
- `RDATA->IDLE`: no pop is accepted.
- `IDLE->IDLE`: no pop is accepted.

Top module: `ssp_stack_unit`

## Requirements
- R1: After reset the pointer is 0xFC00, the lower limit is 0xFA00, the upper limit is 0xFC00, both flags are 0, `pop_valid_o` is 0, and neither RAM strobe is active.
- R2: An accepted push drives `mem_we_o`=1 with `mem_addr_o` set to the next pointer and `mem_wdata_o` set to `push_data_i` in the same cycle. The pointer takes the next pointer at the clock edge. Outside circular mode the next pointer is the pointer minus 2.
- R3: An accepted pop drives `mem_re_o`=1 with `mem_addr_o` set to the current pointer. Outside circular mode the pointer becomes the pointer plus 2. In the following cycle `pop_valid_o`=1 and `pop_data_o` carries the word read.
- R4: A push whose next pointer is below the lower limit sets `ovf_o`. The flag stays set until a cycle with `ovf_clr_i`=1. If a set and a clear fall in the same cycle, the set wins.
- R5: A pop whose next pointer is above the upper limit sets `unf_o`, with the same sticky behaviour through `unf_clr_i`.
- R6: The size code gives the window as follows:
  - 000: 256 words, 0xFBFE..0xFA00
  - 001: 128 words, 0xFBFE..0xFB00
  - 010: 64 words, 0xFBFE..0xFB80
  - 011: 32 words, 0xFBFE..0xFBC0
  - 100: 512 words, 0xFBFE..0xF800
  - 111: 1024 words, 0xFDFE..0xF600

  The window is reported on `win_top_o` and `win_bot_o`.
- R7: Codes 101 and 110 drive `size_bad_o`=1. They report the 256-word window and never wrap. All other codes drive `size_bad_o`=0.
- R8: With `circ_en_i`=1 and a legal code other than 111, a window of N words replaces only the low log2(2N) pointer bits with those of the pointer ±2. A push from the window bottom therefore lands on the window top, and a pop from the top lands on the bottom.
- R9: With code 111, circular mode is ignored and the pointer moves linearly.
- R10: When `push_i` and `pop_i` are both high in the same cycle, nothing happens. No RAM strobe is driven and the pointer and flags are unchanged.
- R11: `sp_wr_i`, `ovl_wr_i` and `unl_wr_i` load `sw_data_i` with bit 0 cleared. `sp_wr_i` blocks a push or pop in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Push strobe |
| pop_i | input | 1 | Pop strobe |
| push_data_i | input | 16 | Word to push |
| pop_data_o | output | 16 | Popped word, valid with pop_valid_o |
| pop_valid_o | output | 1 | Popped word is present this cycle |
| mem_addr_o | output | 16 | RAM byte address |
| mem_we_o | output | 1 | RAM write strobe |
| mem_re_o | output | 1 | RAM read strobe |
| mem_wdata_o | output | 16 | RAM write data |
| mem_rdata_i | input | 16 | RAM read data, one cycle after mem_re_o |
| sw_data_i | input | 16 | Software write value |
| sp_wr_i | input | 1 | Load the pointer |
| ovl_wr_i | input | 1 | Load the lower limit |
| unl_wr_i | input | 1 | Load the upper limit |
| size_i | input | 3 | Stack size code |
| circ_en_i | input | 1 | Circular mode enable |
| ovf_clr_i | input | 1 | Clear the overflow flag |
| unf_clr_i | input | 1 | Clear the underflow flag |
| sp_o | output | 16 | Current pointer |
| ovl_o | output | 16 | Lower limit register |
| unl_o | output | 16 | Upper limit register |
| win_top_o | output | 16 | Highest word address of the window |
| win_bot_o | output | 16 | Lowest word address of the window |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |
| size_bad_o | output | 1 | Reserved size code selected |

## Verification
The bench pushes until the pointer reaches the lower limit, then pushes once more. A limit compare that is off by one word would flag too early or one push late. It pops an empty stack to catch an underflow compare that uses the old pointer. It steps the pointer across both ends of a 32-word window in circular mode. A design that wraps with the wrong mask, or that also rewrites the high bits, would land at the wrong address. It also selects code 111 and a reserved code with circular mode on, so that a design that wraps in those cases leaves the window linearly at the wrong place. It collides push with pop and a pointer load with a push, which catches a design that lets a strobe through.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int unsigned SSP_AW = 16;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2
    } ssp_op_e;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_RDATA = 1'b1
    } ssp_state_e;

    localparam logic [2:0] SZ_256  = 3'b000;
    localparam logic [2:0] SZ_128  = 3'b001;
    localparam logic [2:0] SZ_64   = 3'b010;
    localparam logic [2:0] SZ_32   = 3'b011;
    localparam logic [2:0] SZ_512  = 3'b100;
    localparam logic [2:0] SZ_RSV5 = 3'b101;
    localparam logic [2:0] SZ_RSV6 = 3'b110;
    localparam logic [2:0] SZ_1K   = 3'b111;

endpackage

// File: rtl/ssp_size_decode.sv
module ssp_size_decode
    import ssp_pkg::*;
#(
    parameter int unsigned AW      = 16,
    parameter logic [AW-1:0] STD_TOP = 16'hFBFE,
    parameter logic [AW-1:0] BIG_TOP = 16'hFDFE
) (
    input  logic [2:0]    size_i,
    input  logic          circ_en_i,
    output logic [AW-1:0] win_top_o,
    output logic [AW-1:0] win_bot_o,
    output logic [AW-1:0] win_mask_o,
    output logic          wrap_en_o,
    output logic          size_bad_o
);

    // log2 of the window span in bytes
    logic [4:0]    span_log2;
    logic          legal;
    logic          wrap_ok;
    logic [AW-1:0] top_sel;

    always_comb begin
        legal   = 1'b1;
        wrap_ok = 1'b1;
        top_sel = STD_TOP;
        unique case (size_i)
            SZ_256:  span_log2 = 5'd9;
            SZ_128:  span_log2 = 5'd8;
            SZ_64:   span_log2 = 5'd7;
            SZ_32:   span_log2 = 5'd6;
            SZ_512:  span_log2 = 5'd10;
            SZ_1K: begin
                span_log2 = 5'd11;
                top_sel   = BIG_TOP;
                wrap_ok   = 1'b0;
            end
            SZ_RSV5, SZ_RSV6: begin
                span_log2 = 5'd9;
                legal     = 1'b0;
                wrap_ok   = 1'b0;
            end
            default: span_log2 = 5'd9;
        endcase
    end

    logic [AW-1:0] mask;
    always_comb begin
        mask = (AW'(1) << span_log2) - AW'(1);
    end

    assign win_mask_o = mask;
    assign win_top_o  = top_sel;
    assign win_bot_o  = top_sel - mask + AW'(1);
    assign size_bad_o = !legal;
    assign wrap_en_o  = circ_en_i && wrap_ok;

    always_comb begin
        assert_win_order_R6: assert (win_bot_o <= win_top_o)
            else $error("window bottom above top");
        assert_bad_no_wrap_R7: assert (!(size_bad_o && wrap_en_o))
            else $error("reserved code allowed wrapping");
    end

endmodule

// File: rtl/ssp_ptr_next.sv
module ssp_ptr_next
    import ssp_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic [AW-1:0] sp_i,
    input  ssp_op_e       op_i,
    input  logic          wrap_en_i,
    input  logic [AW-1:0] mask_i,
    output logic [AW-1:0] next_o
);

    localparam logic [AW-1:0] STEP = AW'(2);

    logic [AW-1:0] linear;

    always_comb begin
        unique case (op_i)
            OP_PUSH: linear = sp_i - STEP;
            OP_POP:  linear = sp_i + STEP;
            default: linear = sp_i;
        endcase
        if (wrap_en_i)
            next_o = (sp_i & ~mask_i) | (linear & mask_i);
        else
            next_o = linear;
    end

endmodule

// File: rtl/ssp_limit_flags.sv
module ssp_limit_flags
    import ssp_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter logic [AW-1:0] OVL_RST = 16'hFA00,
    parameter logic [AW-1:0] UNL_RST = 16'hFC00
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ssp_op_e       op_i,
    input  logic [AW-1:0] next_i,
    input  logic [AW-1:0] sw_data_i,
    input  logic          ovl_wr_i,
    input  logic          unl_wr_i,
    input  logic          ovf_clr_i,
    input  logic          unf_clr_i,
    output logic [AW-1:0] ovl_o,
    output logic [AW-1:0] unl_o,
    output logic          ovf_o,
    output logic          unf_o
);

    logic [AW-1:0] ovl_q, unl_q;
    logic          ovf_q, unf_q;
    logic          ovf_set, unf_set;
    logic [AW-1:0] aligned;

    assign aligned = {sw_data_i[AW-1:1], 1'b0};
    assign ovf_set = (op_i == OP_PUSH) && (next_i < ovl_q);
    assign unf_set = (op_i == OP_POP)  && (next_i > unl_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovl_q <= OVL_RST;
            unl_q <= UNL_RST;
        end else begin
            if (ovl_wr_i) ovl_q <= aligned;
            if (unl_wr_i) unl_q <= aligned;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            if (ovf_set)        ovf_q <= 1'b1;
            else if (ovf_clr_i) ovf_q <= 1'b0;
            if (unf_set)        unf_q <= 1'b1;
            else if (unf_clr_i) unf_q <= 1'b0;
        end
    end

    assign ovl_o = ovl_q;
    assign unl_o = unl_q;
    assign ovf_o = ovf_q;
    assign unf_o = unf_q;

    assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !ovf_clr_i) |=> ovf_q)
        else $error("overflow flag dropped without clear");

    assert_unf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_q && !unf_clr_i) |=> unf_q)
        else $error("underflow flag dropped without clear");

    assert_ovf_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_q) |-> $past(op_i == OP_PUSH))
        else $error("overflow without push");

    assert_unf_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unf_q) |-> $past(op_i == OP_POP))
        else $error("underflow without pop");

endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
    import ssp_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    push_i,
    input  logic    pop_i,
    input  logic    sp_wr_i,
    output ssp_op_e op_o,
    output logic    pop_valid_o
);

    ssp_state_e state_q, state_d;
    ssp_op_e    op;

    // operation selection: collisions and pointer loads suppress the stack op
    always_comb begin
        op = OP_NONE;
        if (!sp_wr_i) begin
            if (push_i && !pop_i)      op = OP_PUSH;
            else if (pop_i && !push_i) op = OP_POP;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (op == OP_POP) state_d = ST_RDATA;
            ST_RDATA: if (op != OP_POP) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        op_o        = op;
        pop_valid_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  pop_valid_o = 1'b0;
            ST_RDATA: pop_valid_o = 1'b1;
            default:  pop_valid_o = 1'b0;
        endcase
    end

    assert_no_collide_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |-> (op_o == OP_NONE))
        else $error("colliding strobes produced an operation");

    assert_pop_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_o == OP_POP) |=> pop_valid_o)
        else $error("pop data not flagged valid");

    assert_swr_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sp_wr_i |-> (op_o == OP_NONE))
        else $error("pointer load did not block operation");

endmodule

// File: rtl/ssp_stack_unit.sv
module ssp_stack_unit
    import ssp_pkg::*;
#(
    parameter int unsigned AW      = 16,
    parameter int unsigned DW      = 16,
    parameter logic [AW-1:0] STD_TOP = 16'hFBFE,
    parameter logic [AW-1:0] BIG_TOP = 16'hFDFE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [DW-1:0] push_data_i,
    output logic [DW-1:0] pop_data_o,
    output logic          pop_valid_o,
    output logic [AW-1:0] mem_addr_o,
    output logic          mem_we_o,
    output logic          mem_re_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic [DW-1:0] mem_rdata_i,
    input  logic [AW-1:0] sw_data_i,
    input  logic          sp_wr_i,
    input  logic          ovl_wr_i,
    input  logic          unl_wr_i,
    input  logic [2:0]    size_i,
    input  logic          circ_en_i,
    input  logic          ovf_clr_i,
    input  logic          unf_clr_i,
    output logic [AW-1:0] sp_o,
    output logic [AW-1:0] ovl_o,
    output logic [AW-1:0] unl_o,
    output logic [AW-1:0] win_top_o,
    output logic [AW-1:0] win_bot_o,
    output logic          ovf_o,
    output logic          unf_o,
    output logic          size_bad_o
);

    localparam logic [AW-1:0] SP_RST  = STD_TOP + AW'(2);
    localparam logic [AW-1:0] OVL_RST = STD_TOP - AW'(16'h01FE);

    ssp_op_e       op;
    logic [AW-1:0] sp_q;
    logic [AW-1:0] sp_next;
    logic [AW-1:0] win_mask;
    logic          wrap_en;

    ssp_size_decode #(
        .AW(AW), .STD_TOP(STD_TOP), .BIG_TOP(BIG_TOP)
    ) u_dec (
        .size_i     (size_i),
        .circ_en_i  (circ_en_i),
        .win_top_o  (win_top_o),
        .win_bot_o  (win_bot_o),
        .win_mask_o (win_mask),
        .wrap_en_o  (wrap_en),
        .size_bad_o (size_bad_o)
    );

    ssp_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push_i),
        .pop_i       (pop_i),
        .sp_wr_i     (sp_wr_i),
        .op_o        (op),
        .pop_valid_o (pop_valid_o)
    );

    ssp_ptr_next #(.AW(AW)) u_next (
        .sp_i      (sp_q),
        .op_i      (op),
        .wrap_en_i (wrap_en),
        .mask_i    (win_mask),
        .next_o    (sp_next)
    );

    ssp_limit_flags #(
        .AW(AW), .OVL_RST(OVL_RST), .UNL_RST(SP_RST)
    ) u_lim (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op),
        .next_i    (sp_next),
        .sw_data_i (sw_data_i),
        .ovl_wr_i  (ovl_wr_i),
        .unl_wr_i  (unl_wr_i),
        .ovf_clr_i (ovf_clr_i),
        .unf_clr_i (unf_clr_i),
        .ovl_o     (ovl_o),
        .unl_o     (unl_o),
        .ovf_o     (ovf_o),
        .unf_o     (unf_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              sp_q <= SP_RST;
        else if (sp_wr_i)        sp_q <= {sw_data_i[AW-1:1], 1'b0};
        else if (op != OP_NONE)  sp_q <= sp_next;
    end

    always_comb begin
        mem_we_o    = (op == OP_PUSH);
        mem_re_o    = (op == OP_POP);
        mem_addr_o  = (op == OP_PUSH) ? sp_next : sp_q;
        mem_wdata_o = push_data_i;
        pop_data_o  = mem_rdata_i;
    end

    assign sp_o = sp_q;

    assert_sp_aligned_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sp_q[0] == 1'b0)
        else $error("pointer not word aligned");

    assert_push_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && !wrap_en) |=> (sp_o == $past(sp_o) - AW'(2)))
        else $error("linear push step wrong");

    assert_pop_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re_o && !wrap_en) |=> (sp_o == $past(sp_o) + AW'(2)))
        else $error("linear pop step wrong");

    assert_wrap_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_we_o || mem_re_o) && wrap_en)
            |=> (((sp_o ^ $past(sp_o)) & ~$past(win_mask)) == '0))
        else $error("circular step touched bits above the window");

    assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we_o && mem_re_o))
        else $error("read and write strobes together");

endmodule

// File: tb/ssp_stack_unit_tb.sv
module ssp_stack_unit_tb_top;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_i = 0, pop_i = 0, sp_wr_i = 0, ovl_wr_i = 0, unl_wr_i = 0;
    logic        circ_en_i = 0, ovf_clr_i = 0, unf_clr_i = 0;
    logic [15:0] push_data_i = 0, sw_data_i = 0;
    logic [2:0]  size_i = 3'b000;
    logic [15:0] pop_data_o, mem_addr_o, mem_wdata_o, sp_o, ovl_o, unl_o;
    logic [15:0] win_top_o, win_bot_o;
    logic [15:0] mem_rdata_i = 0;
    logic        pop_valid_o, mem_we_o, mem_re_o, ovf_o, unf_o, size_bad_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ssp_stack_unit dut_i (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
        .push_data_i(push_data_i), .pop_data_o(pop_data_o), .pop_valid_o(pop_valid_o),
        .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o), .mem_re_o(mem_re_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .sw_data_i(sw_data_i),
        .sp_wr_i(sp_wr_i), .ovl_wr_i(ovl_wr_i), .unl_wr_i(unl_wr_i), .size_i(size_i),
        .circ_en_i(circ_en_i), .ovf_clr_i(ovf_clr_i), .unf_clr_i(unf_clr_i),
        .sp_o(sp_o), .ovl_o(ovl_o), .unl_o(unl_o), .win_top_o(win_top_o),
        .win_bot_o(win_bot_o), .ovf_o(ovf_o), .unf_o(unf_o), .size_bad_o(size_bad_o)
    );

    // RAM stand-in with one-cycle read latency
    logic [15:0] bmem [int];
    always @(posedge clk) begin
        if (mem_we_o) bmem[int'(mem_addr_o)] = mem_wdata_o;
        if (mem_re_o) mem_rdata_i <= bmem.exists(int'(mem_addr_o)) ? bmem[int'(mem_addr_o)] : 16'h0;
    end

    // behavioural reference state
    int          m_sp, m_ovl, m_unl;
    bit          m_ovf, m_unf, m_pend;
    int          m_pdata;
    int          m_mem [int];

    function automatic void chk(string tag, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endfunction

    function automatic int span_bytes(logic [2:0] c);
        case (c)
            3'b000: return 512;
            3'b001: return 256;
            3'b010: return 128;
            3'b011: return 64;
            3'b100: return 1024;
            3'b111: return 2048;
            default: return 512;
        endcase
    endfunction

    function automatic int win_top(logic [2:0] c);
        return (c == 3'b111) ? 'hFDFE : 'hFBFE;
    endfunction

    function automatic int step_ptr(int sp, bit is_push);
        int lin, span;
        bit wrap;
        lin  = (is_push ? sp - 2 : sp + 2) & 'hFFFF;
        span = span_bytes(size_i);
        wrap = circ_en_i && size_i != 3'b111 && size_i != 3'b101 && size_i != 3'b110;
        if (!wrap) return lin;
        return (sp - (sp % span)) + (lin % span);
    endfunction

    task automatic step(string tag);
        bit do_push, do_pop;
        int nsp;
        #1;
        do_push = push_i && !pop_i && !sp_wr_i;
        do_pop  = pop_i && !push_i && !sp_wr_i;
        nsp = m_sp;
        if (do_push) nsp = step_ptr(m_sp, 1);
        if (do_pop)  nsp = step_ptr(m_sp, 0);
        chk(tag, "mem_we", int'(mem_we_o), int'(do_push));
        chk(tag, "mem_re", int'(mem_re_o), int'(do_pop));
        if (do_push) begin
            chk(tag, "push addr", int'(mem_addr_o), nsp);
            chk(tag, "push data", int'(mem_wdata_o), int'(push_data_i));
        end
        if (do_pop) chk(tag, "pop addr", int'(mem_addr_o), m_sp);
        chk(tag, "win_top", int'(win_top_o), win_top(size_i));
        chk(tag, "win_bot", int'(win_bot_o), win_top(size_i) - span_bytes(size_i) + 2);
        chk(tag, "size_bad", int'(size_bad_o), int'(size_i == 3'b101 || size_i == 3'b110));
        @(posedge clk);
        // reference update
        m_pend = do_pop;
        if (do_pop) m_pdata = m_mem.exists(m_sp) ? m_mem[m_sp] : 0;
        if (do_push) m_mem[nsp] = int'(push_data_i);
        if (do_push && nsp < m_ovl) m_ovf = 1;
        else if (ovf_clr_i) m_ovf = 0;
        if (do_pop && nsp > m_unl) m_unf = 1;
        else if (unf_clr_i) m_unf = 0;
        if (ovl_wr_i) m_ovl = int'(sw_data_i) & 'hFFFE;
        if (unl_wr_i) m_unl = int'(sw_data_i) & 'hFFFE;
        if (sp_wr_i) m_sp = int'(sw_data_i) & 'hFFFE;
        else m_sp = nsp;
        #1;
        chk(tag, "sp", int'(sp_o), m_sp);
        chk(tag, "ovf", int'(ovf_o), int'(m_ovf));
        chk(tag, "unf", int'(unf_o), int'(m_unf));
        chk(tag, "ovl", int'(ovl_o), m_ovl);
        chk(tag, "unl", int'(unl_o), m_unl);
        chk(tag, "pop_valid", int'(pop_valid_o), int'(m_pend));
        if (m_pend) chk(tag, "pop data", int'(pop_data_o), m_pdata);
        @(negedge clk);
        push_i = 0; pop_i = 0; sp_wr_i = 0; ovl_wr_i = 0; unl_wr_i = 0;
        ovf_clr_i = 0; unf_clr_i = 0;
    endtask

    task automatic do_push(string tag, logic [15:0] d);
        push_i = 1; push_data_i = d; step(tag);
    endtask
    task automatic do_pop(string tag);
        pop_i = 1; step(tag);
    endtask
    task automatic load_sp(string tag, logic [15:0] v);
        sp_wr_i = 1; sw_data_i = v; step(tag);
    endtask
    task automatic load_lims(string tag, logic [15:0] lo, logic [15:0] hi);
        ovl_wr_i = 1; sw_data_i = lo; step(tag);
        unl_wr_i = 1; sw_data_i = hi; step(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        m_sp = 'hFC00; m_ovl = 'hFA00; m_unl = 'hFC00;
        m_ovf = 0; m_unf = 0; m_pend = 0; m_pdata = 0;
        repeat (3) @(negedge clk);
        // R1: reset values before release
        chk("R1", "sp rst", int'(sp_o), 'hFC00);
        chk("R1", "ovl rst", int'(ovl_o), 'hFA00);
        chk("R1", "unl rst", int'(unl_o), 'hFC00);
        chk("R1", "flags rst", int'({ovf_o, unf_o, pop_valid_o, mem_we_o, mem_re_o}), 0);
        rst_n = 1;
        @(negedge clk);

        // R2 / R3: LIFO behaviour, back-to-back pops
        do_push("R2", 16'h1111);
        do_push("R2", 16'h2222);
        do_push("R2", 16'h3333);
        do_pop("R3"); do_pop("R3"); do_pop("R3");
        step("R3");
        // R5: pop from empty stack
        do_pop("R5");
        step("R5");
        unf_clr_i = 1; step("R5");
        // R11: aligned load, R4: overflow edge
        load_sp("R11", 16'hFA03);
        do_push("R4", 16'hAAAA);
        do_push("R4", 16'hBBBB);
        step("R4"); step("R4");
        ovf_clr_i = 1; do_push("R4", 16'hCCCC);
        ovf_clr_i = 1; step("R4");
        // R10: collision
        push_i = 1; pop_i = 1; push_data_i = 16'h5555; step("R10");
        // R11: pointer load blocks push
        push_i = 1; push_data_i = 16'h6666; sp_wr_i = 1; sw_data_i = 16'hFB00; step("R11");
        // R6 / R7: every code
        for (int c = 0; c < 8; c++) begin
            size_i = c[2:0];
            step((c == 5 || c == 6) ? "R7" : "R6");
        end
        // R8: circular in 32-word window
        size_i = 3'b011; circ_en_i = 1;
        load_lims("R8", 16'h0000, 16'hFFFE);
        load_sp("R8", 16'hFBC0);
        do_push("R8", 16'h7777);
        do_pop("R8");
        chk("R8", "wrap to bottom", int'(sp_o), 'hFBC0);
        do_pop("R8");
        do_push("R8", 16'h8888);
        // R8: 128-word window
        size_i = 3'b001; load_sp("R8", 16'hFB00);
        do_push("R8", 16'h9999);
        chk("R8", "wrap to top", int'(sp_o), 'hFBFE);
        // R9: largest size ignores circular mode
        size_i = 3'b111; load_sp("R9", 16'hF600);
        do_push("R9", 16'hABCD);
        chk("R9", "linear exit", int'(sp_o), 'hF5FE);
        // R7: reserved code ignores circular mode
        size_i = 3'b101; load_sp("R7", 16'hFA00);
        do_push("R7", 16'h1234);
        chk("R7", "linear exit", int'(sp_o), 'hF9FE);
        do_pop("R7");
        circ_en_i = 0; size_i = 3'b000;
        step("R2");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule